// File: doc/BRIEF.md
# Space-Time-Space Message Permuter

This block carries P messages per clock between two groups of P processing elements. Each message goes first through a port-to-port switch. It is then held in one of P small interleaver memories, and finally passes through a second port-to-port switch. The memories are written in one order and read in another, so traffic can be reordered in time as well as in space. With that, a consumer can receive its messages in whatever edge order the code graph needs, which a single crossbar cannot provide.

A control word arrives with every clock and sets the whole path for that cycle. For each input lane it gives the target bank, a write enable and the message. For each bank it gives a write address and a read address. For each output lane it gives the source bank. Any of these settings may change from one cycle to the next. The same instance serves the variable-to-check direction and the check-to-variable direction; only the schedule changes. Bank depth is a parameter sized to the largest number of messages one lane handles in a half iteration.

Top module: `stp_permuter`

## Requirements
- R1: While rst_ni is low, msg_valid_o is 0 and msg_o is all zeros.
- R2: msg_valid_o is 1 in the cycle after the second rising edge that follows a cycle with ctl_valid_i high, and 0 otherwise (fixed latency of 2 clocks).
- R3: In a cycle with ctl_valid_i high, input lane p whose bit msg_en_i[p] is 1 writes its message into bank in_dest_i[p] (field p, SEL_W bits wide) at address wr_addr_i of that bank (field b, ADDR_W bits wide).
- R4: In each cycle with ctl_valid_i high, every bank b reads the word at rd_addr_i field b. If the same bank and address are written in that same cycle, the read returns the old content.
- R5: Output lane q carries the word read from bank out_src_i[q] (field q), where out_src_i is taken in the same cycle as the read. Several lanes may select the same bank.
- R6: An input lane whose msg_en_i bit is 0 writes nothing, and the addressed bank location keeps its content.
- R7: In a cycle with ctl_valid_i low nothing is written or read, and msg_o keeps its value whenever msg_valid_o is 0.
- R8: Enabled input lanes in one valid cycle must name distinct banks. A bank is never written twice in one cycle.
- R9: Switch settings, addresses and enables take effect in their own cycle, so back-to-back cycles with different settings each give their own result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctl_valid_i | input | 1 | Control word and messages valid this cycle |
| msg_i | input | P*W | Input messages, lane p at bits p*W +: W |
| msg_en_i | input | P | Per-lane write enable |
| in_dest_i | input | P*SEL_W | Target bank for each input lane |
| wr_addr_i | input | P*ADDR_W | Write address for each bank |
| rd_addr_i | input | P*ADDR_W | Read address for each bank |
| out_src_i | input | P*SEL_W | Source bank for each output lane |
| msg_o | output | P*W | Output messages, lane q at bits q*W +: W |
| msg_valid_o | output | 1 | Output messages valid |

## Verification
The assertions assume the schedule never sends two enabled input lanes to the same bank in one valid cycle. They also assume that reads only touch locations written earlier, so output data is never unknown when it is checked. The stimulus builds every input routing as a rotation of the lanes, so the targets are distinct by construction. It fills every bank location before the first read whose data is compared. The read data from that fill phase is left unchecked, and only its timing is compared.

// File: rtl/stp_pkg.sv
package stp_pkg;
  // index width that stays at least one bit
  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/stp_in_switch.sv
module stp_in_switch #(
  parameter int P     = 4,
  parameter int W     = 8,
  parameter int SEL_W = 2
) (
  input  logic               valid_i,
  input  logic [P*W-1:0]     msg_i,
  input  logic [P-1:0]       en_i,
  input  logic [P*SEL_W-1:0] dest_i,
  output logic [P*W-1:0]     bank_data_o,
  output logic [P-1:0]       bank_we_o
);
  for (genvar b = 0; b < P; b++) begin : g_bank
    always_comb begin
      bank_we_o[b]           = 1'b0;
      bank_data_o[b*W +: W]  = '0;
      // lowest lane wins; schedule forbids a second one
      for (int p = P - 1; p >= 0; p--) begin
        if (valid_i && en_i[p] && (dest_i[p*SEL_W +: SEL_W] == SEL_W'(b))) begin
          bank_we_o[b]          = 1'b1;
          bank_data_o[b*W +: W] = msg_i[p*W +: W];
        end
      end
    end
  end
endmodule

// File: rtl/stp_bank.sv
module stp_bank #(
  parameter int W      = 8,
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [W-1:0]      wdata_i,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [W-1:0]      rdata_o
);
  logic [W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  // read-first: same-cycle write is not visible
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (re_i) rdata_o <= mem_q[raddr_i];
  end
endmodule

// File: rtl/stp_out_switch.sv
module stp_out_switch #(
  parameter int P     = 4,
  parameter int W     = 8,
  parameter int SEL_W = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic [P*W-1:0]     rd_data_i,
  input  logic [P*SEL_W-1:0] src_i,
  output logic [P*W-1:0]     msg_o,
  output logic               valid_o
);
  logic [P*W-1:0] mux_d;

  for (genvar q = 0; q < P; q++) begin : g_lane
    always_comb begin
      mux_d[q*W +: W] = '0;
      for (int b = 0; b < P; b++) begin
        if (src_i[q*SEL_W +: SEL_W] == SEL_W'(b)) mux_d[q*W +: W] = rd_data_i[b*W +: W];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      msg_o   <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) msg_o <= mux_d;
    end
  end
endmodule

// File: rtl/stp_permuter.sv
module stp_permuter #(
  parameter int P      = 4,
  parameter int W      = 8,
  parameter int DEPTH  = 8,
  parameter int SEL_W  = stp_pkg::idx_w(P),
  parameter int ADDR_W = stp_pkg::idx_w(DEPTH)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                ctl_valid_i,
  input  logic [P*W-1:0]      msg_i,
  input  logic [P-1:0]        msg_en_i,
  input  logic [P*SEL_W-1:0]  in_dest_i,
  input  logic [P*ADDR_W-1:0] wr_addr_i,
  input  logic [P*ADDR_W-1:0] rd_addr_i,
  input  logic [P*SEL_W-1:0]  out_src_i,
  output logic [P*W-1:0]      msg_o,
  output logic                msg_valid_o
);
  logic [P*W-1:0]     bank_wdata;
  logic [P-1:0]       bank_we;
  logic [P*W-1:0]     bank_rdata;
  logic [P*SEL_W-1:0] src_q;
  logic               vld_q;

  stp_in_switch #(.P(P), .W(W), .SEL_W(SEL_W)) u_in_sw (
    .valid_i     (ctl_valid_i),
    .msg_i       (msg_i),
    .en_i        (msg_en_i),
    .dest_i      (in_dest_i),
    .bank_data_o (bank_wdata),
    .bank_we_o   (bank_we)
  );

  for (genvar b = 0; b < P; b++) begin : g_bank
    stp_bank #(.W(W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_bank (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (bank_we[b]),
      .waddr_i (wr_addr_i[b*ADDR_W +: ADDR_W]),
      .wdata_i (bank_wdata[b*W +: W]),
      .re_i    (ctl_valid_i),
      .raddr_i (rd_addr_i[b*ADDR_W +: ADDR_W]),
      .rdata_o (bank_rdata[b*W +: W])
    );
  end

  // align output routing with registered read data
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      src_q <= '0;
    end else begin
      vld_q <= ctl_valid_i;
      if (ctl_valid_i) src_q <= out_src_i;
    end
  end

  stp_out_switch #(.P(P), .W(W), .SEL_W(SEL_W)) u_out_sw (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (vld_q),
    .rd_data_i (bank_rdata),
    .src_i     (src_q),
    .msg_o     (msg_o),
    .valid_o   (msg_valid_o)
  );
endmodule

// File: rtl/stp_permuter_chk.sv
module stp_permuter_chk #(
  parameter int P     = 4,
  parameter int W     = 8,
  parameter int SEL_W = 2
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               ctl_valid_i,
  input logic [P-1:0]       msg_en_i,
  input logic [P*SEL_W-1:0] in_dest_i,
  input logic [P*W-1:0]     msg_o,
  input logic               msg_valid_o
);
  logic collide;

  always_comb begin
    collide = 1'b0;
    for (int a = 0; a < P; a++) begin
      for (int c = a + 1; c < P; c++) begin
        if (msg_en_i[a] && msg_en_i[c] &&
            (in_dest_i[a*SEL_W +: SEL_W] == in_dest_i[c*SEL_W +: SEL_W])) collide = 1'b1;
      end
    end
  end

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      p_reset_quiet_r1: assert (msg_valid_o == 1'b0 && msg_o == '0)
        else $error("R1: outputs not cleared in reset");
    end
  end

  p_no_collision_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_valid_i |-> !collide)
    else $error("R8: two enabled lanes target one bank");

  p_latency_on_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_valid_i |=> ##1 msg_valid_o)
    else $error("R2: valid did not appear after 2 clocks");

  p_latency_off_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctl_valid_i |=> ##1 !msg_valid_o)
    else $error("R2: spurious output valid");

  p_hold_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !msg_valid_o |-> $stable(msg_o))
    else $error("R7: output changed while not valid");
endmodule

bind stp_permuter stp_permuter_chk #(.P(P), .W(W), .SEL_W(SEL_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ctl_valid_i (ctl_valid_i),
  .msg_en_i    (msg_en_i),
  .in_dest_i   (in_dest_i),
  .msg_o       (msg_o),
  .msg_valid_o (msg_valid_o)
);

// File: tb/stp_permuter_bench.sv
`timescale 1ns/1ps
module stp_permuter_bench;
  localparam int P      = 4;
  localparam int W      = 8;
  localparam int DEPTH  = 8;
  localparam int SEL_W  = 2;
  localparam int ADDR_W = 3;

  logic                clk_i = 1'b0;
  logic                rst_ni = 1'b0;
  logic                ctl_valid_i = 1'b0;
  logic [P*W-1:0]      msg_i = '0;
  logic [P-1:0]        msg_en_i = '0;
  logic [P*SEL_W-1:0]  in_dest_i = '0;
  logic [P*ADDR_W-1:0] wr_addr_i = '0;
  logic [P*ADDR_W-1:0] rd_addr_i = '0;
  logic [P*SEL_W-1:0]  out_src_i = '0;
  logic [P*W-1:0]      msg_o;
  logic                msg_valid_o;

  always #2.5 clk_i = ~clk_i;

  stp_permuter #(.P(P), .W(W), .DEPTH(DEPTH)) u_stp_permuter (
    .clk_i, .rst_ni, .ctl_valid_i, .msg_i, .msg_en_i, .in_dest_i,
    .wr_addr_i, .rd_addr_i, .out_src_i, .msg_o, .msg_valid_o
  );

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;
  always @(posedge clk_i) cyc <= cyc + 1;

  // reference storage and staging of one control word
  logic [W-1:0] mem_m [P][DEPTH];
  int d_msg [P], d_en [P], d_dest [P], d_wa [P], d_ra [P], d_src [P];

  logic [P*W-1:0] exp_data_q [$];
  int             exp_cyc_q  [$];
  string          exp_tag_q  [$];
  logic [P*W-1:0] last_out = '0;

  task automatic check(input bit ok, input string tag, input logic [P*W-1:0] act, exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input bit v, input string tag);
    logic [P*W-1:0] e;
    @(negedge clk_i);
    ctl_valid_i = v;
    for (int i = 0; i < P; i++) begin
      msg_i[i*W +: W]              = d_msg[i][W-1:0];
      msg_en_i[i]                  = d_en[i][0];
      in_dest_i[i*SEL_W +: SEL_W]  = d_dest[i][SEL_W-1:0];
      wr_addr_i[i*ADDR_W +: ADDR_W] = d_wa[i][ADDR_W-1:0];
      rd_addr_i[i*ADDR_W +: ADDR_W] = d_ra[i][ADDR_W-1:0];
      out_src_i[i*SEL_W +: SEL_W]  = d_src[i][SEL_W-1:0];
    end
    if (v) begin
      for (int q = 0; q < P; q++) e[q*W +: W] = mem_m[d_src[q]][d_ra[d_src[q]]];
      exp_data_q.push_back(e);
      exp_cyc_q.push_back(cyc);
      exp_tag_q.push_back(tag);
      for (int i = 0; i < P; i++)
        if (d_en[i] != 0) mem_m[d_dest[i]][d_wa[d_dest[i]]] = d_msg[i][W-1:0];
    end
  endtask

  task automatic set_rot(input int k, input int en);
    for (int i = 0; i < P; i++) begin
      d_dest[i] = (i + k) % P;
      d_en[i]   = en;
      d_msg[i]  = int'($urandom_range(255));
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (msg_valid_o) begin
        if (exp_data_q.size() == 0) begin
          check(1'b0, "R2 unexpected valid", msg_o, '0);
        end else begin
          logic [P*W-1:0] e;
          int c;
          string t;
          e = exp_data_q.pop_front();
          c = exp_cyc_q.pop_front();
          t = exp_tag_q.pop_front();
          check(cyc == c + 2, "R2 latency", P*W'(cyc), P*W'(c + 2));
          if (t != "") check(msg_o === e, t, msg_o, e);
          last_out = msg_o;
        end
      end else begin
        check(msg_o === last_out, "R7 hold while idle", msg_o, last_out);
      end
    end
  end

  initial begin
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < P; i++) begin
      d_msg[i] = 0; d_en[i] = 0; d_dest[i] = i; d_wa[i] = 0; d_ra[i] = 0; d_src[i] = i;
    end
    repeat (2) @(negedge clk_i);
    check(msg_valid_o === 1'b0, "R1 valid in reset", {31'd0, msg_valid_o}, '0);
    check(msg_o === '0, "R1 data in reset", msg_o, '0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // fill every location, rotating lane-to-bank routing (R3, R8)
    for (int a = 0; a < DEPTH; a++) begin
      set_rot(a % P, 1);
      for (int b = 0; b < P; b++) d_wa[b] = a;
      step(1'b1, "");
    end
    for (int i = 0; i < P; i++) d_en[i] = 0;

    // reversed, per-bank distinct read order with rotated output routing (R4, R5)
    for (int a = 0; a < DEPTH; a++) begin
      for (int b = 0; b < P; b++) begin
        d_ra[b]  = (DEPTH - 1 - a + b) % DEPTH;
        d_src[b] = (b + a + 1) % P;
      end
      step(1'b1, "R4 R5 reorder read");
    end

    // broadcast one bank to all lanes (R5)
    for (int k = 0; k < P; k++) begin
      for (int q = 0; q < P; q++) d_src[q] = k;
      step(1'b1, "R5 broadcast");
    end
    for (int q = 0; q < P; q++) d_src[q] = q;

    // read and write the same address in one cycle: old data (R4), then new data (R3)
    set_rot(1, 1);
    for (int b = 0; b < P; b++) begin d_wa[b] = 5; d_ra[b] = 5; end
    step(1'b1, "R4 read-first");
    set_rot(0, 0);
    step(1'b1, "R3 written data");

    // disabled lanes leave the bank untouched (R6)
    set_rot(2, 0);
    d_en[0] = 1;
    for (int b = 0; b < P; b++) begin d_wa[b] = 3; d_ra[b] = 3; end
    step(1'b1, "R6 partial enable");
    for (int i = 0; i < P; i++) d_en[i] = 0;
    step(1'b1, "R6 readback");

    // invalid cycles with enables set: no write, outputs hold (R7)
    set_rot(3, 1);
    for (int b = 0; b < P; b++) d_wa[b] = 6;
    repeat (3) step(1'b0, "R7");
    for (int i = 0; i < P; i++) d_en[i] = 0;
    for (int b = 0; b < P; b++) d_ra[b] = 6;
    step(1'b1, "R7 no write when invalid");

    // back-to-back changing settings with gaps (R9)
    for (int n = 0; n < 60; n++) begin
      set_rot(int'($urandom_range(P - 1)), 0);
      for (int i = 0; i < P; i++) begin
        d_en[i]  = int'($urandom_range(1));
        d_wa[i]  = int'($urandom_range(DEPTH - 1));
        d_ra[i]  = int'($urandom_range(DEPTH - 1));
        d_src[i] = int'($urandom_range(P - 1));
      end
      step((n % 7) != 6, "R9 per-cycle settings");
    end

    for (int i = 0; i < P; i++) d_en[i] = 0;
    repeat (6) step(1'b0, "");
    check(exp_data_q.size() == 0, "R2 all outputs delivered",
          P*W'(exp_data_q.size()), '0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule